// File: doc/BRIEF.md
# Bit-Count, Pack and Logic Unit

This block is a purely combinational execution unit for an integer datapath whose width is set by a parameter, either 32 or 64 bits. Each evaluation takes two source operands, A and B, and a 5-bit operation code, and returns one datapath-wide result. The supported operations fall into these groups:

- bit counting: leading zeros, trailing zeros and set bits;
- bitwise logic in which operand B is inverted;
- signed and unsigned minimum and maximum;
- sign extension from a byte or from a halfword;
- three ways of packing fields of A and B into one word.

The unit sits beside the adder and shifter in an execute stage. The surrounding pipeline registers its output. A separate flag marks operation codes that the unit does not implement, so that the decoder can raise an exception for them.

Top module: `bitpack_unit`

## Requirements
- R1: Code 0 returns the number of leading zero bits of A. For A equal to zero it returns XLEN.
- R2: Code 1 returns the number of trailing zero bits of A. For A equal to zero it returns XLEN.
- R3: Code 2 returns the number of one bits in A, zero-extended to XLEN bits.
- R4: Code 3 returns A & ~B, code 4 returns A | ~B and code 5 returns ~(A ^ B).
- R5: Code 6 returns the smaller and code 7 the larger of A and B, both read as two's-complement signed values.
- R6: Code 8 returns the smaller and code 9 the larger of A and B, both read as unsigned magnitudes.
- R7: Code 10 copies A[7] into every result bit above bit 7, keeping A[7:0]. Code 11 copies A[15] into every bit above bit 15, keeping A[15:0].
- R8: Code 12 returns A's low half in the result's low half and B's low half in the result's high half.
- R9: Code 13 returns A's high half in the result's low half and B's high half in the result's high half.
- R10: Code 14 returns A[7:0] in bits 7:0 and B[7:0] in bits 15:8, with every bit above 15 zero.
- R11: Codes 15 to 31 give an all-zero result and raise the illegal flag at once. Codes 0 to 14 keep the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| src_a_i | input | XLEN | First source operand |
| src_b_i | input | XLEN | Second source operand |
| result_o | output | XLEN | Operation result |
| illegal_o | output | 1 | Raised for an unimplemented operation code |

## Verification
Every code is driven with the corner operands zero, all ones, the most negative value and the value 1.

- An all-zero A separates the defined count-of-width result from a zero or wrapped count.
- Pairing the most negative value against 1 tells a signed comparison from an unsigned one.
- Operands whose halves and low bytes all differ show any swapped or misplaced field in the packing layouts.

Random operands then cover the general case for each code. A sweep of every unused code confirms the zero result and the raised flag.

// File: rtl/bpu_pkg.sv
// Shared operation codes for the bit-count, pack and logic unit.
// Assumes a 5-bit code; any value not listed here is unimplemented.
package bpu_pkg;

    typedef enum logic [4:0] {
        OP_LZCNT  = 5'd0,
        OP_TZCNT  = 5'd1,
        OP_POPCNT = 5'd2,
        OP_ANDINV = 5'd3,
        OP_ORINV  = 5'd4,
        OP_XNOR   = 5'd5,
        OP_SMIN   = 5'd6,
        OP_SMAX   = 5'd7,
        OP_UMIN   = 5'd8,
        OP_UMAX   = 5'd9,
        OP_SXBYTE = 5'd10,
        OP_SXHALF = 5'd11,
        OP_PKLO   = 5'd12,
        OP_PKHI   = 5'd13,
        OP_PKBYTE = 5'd14
    } bpu_op_e;

    localparam int unsigned OP_CODE_W   = 5;
    localparam int unsigned OP_LAST_IMP = 14;

endpackage

// File: rtl/bpu_count.sv
// Bit counters: leading zeros, trailing zeros and set bits of one operand.
// Assumes XLEN >= 2. An all-zero operand yields XLEN for both zero counts.
module bpu_count #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned CW  = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] val_i,
    output logic [CW-1:0]   lead_o,
    output logic [CW-1:0]   trail_o,
    output logic [CW-1:0]   ones_o
);

    // Leading zeros: the highest set bit is the last one to write the count.
    always_comb begin
        lead_o = CW'(XLEN);
        for (int i = 0; i < int'(XLEN); i++) begin
            if (val_i[i]) begin
                lead_o = CW'(int'(XLEN) - 1 - i);
            end
        end
    end

    // Trailing zeros: the lowest set bit is the last one to write the count.
    always_comb begin
        trail_o = CW'(XLEN);
        for (int i = int'(XLEN) - 1; i >= 0; i--) begin
            if (val_i[i]) begin
                trail_o = CW'(i);
            end
        end
    end

    // Population count: a plain sum of all bits.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < int'(XLEN); i++) begin
            ones_o = ones_o + CW'(val_i[i]);
        end
    end

endmodule

// File: rtl/bpu_logic.sv
// Inverted-operand logic, signed and unsigned min/max, and sign extension.
// Assumes XLEN >= 16 so that the halfword extension has bits to fill.
module bpu_logic #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] andinv_o,
    output logic [XLEN-1:0] orinv_o,
    output logic [XLEN-1:0] xnor_o,
    output logic [XLEN-1:0] smin_o,
    output logic [XLEN-1:0] smax_o,
    output logic [XLEN-1:0] umin_o,
    output logic [XLEN-1:0] umax_o,
    output logic [XLEN-1:0] sxbyte_o,
    output logic [XLEN-1:0] sxhalf_o
);

    logic a_lt_s;
    logic a_lt_u;

    // Bitwise operations in which operand B is inverted.
    always_comb begin
        andinv_o = a_i & ~b_i;
        orinv_o  = a_i | ~b_i;
        xnor_o   = ~(a_i ^ b_i);
    end

    // Two magnitude comparisons shared by the four min/max selections.
    always_comb begin
        a_lt_s = $signed(a_i) < $signed(b_i);
        a_lt_u = a_i < b_i;
    end

    // Pick the minimum and maximum from the comparison results.
    always_comb begin
        smin_o = a_lt_s ? a_i : b_i;
        smax_o = a_lt_s ? b_i : a_i;
        umin_o = a_lt_u ? a_i : b_i;
        umax_o = a_lt_u ? b_i : a_i;
    end

    // Replicate the byte or halfword sign bit upward.
    always_comb begin
        sxbyte_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
        sxhalf_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
    end

endmodule

// File: rtl/bpu_pack.sv
// Operand packing: low halves, high halves, and two low bytes.
// Assumes XLEN is even and at least 16.
module bpu_pack #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] pklo_o,
    output logic [XLEN-1:0] pkhi_o,
    output logic [XLEN-1:0] pkbyte_o
);

    // Join the half-width fields of both operands.
    always_comb begin
        pklo_o = {b_i[HALF-1:0], a_i[HALF-1:0]};
        pkhi_o = {b_i[XLEN-1:HALF], a_i[XLEN-1:HALF]};
    end

    // Join the two low bytes and clear everything above them.
    always_comb begin
        pkbyte_o = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};
    end

endmodule

// File: rtl/bitpack_unit.sv
// Top of the bit-count, pack and logic unit. It is purely combinational,
// with no clock and no state. It assumes XLEN is 32 or 64. Each operation
// has its own datapath; a final multiplexer on the operation code picks
// one result. Unimplemented codes give zero and raise illegal_o.
module bitpack_unit
    import bpu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [OP_CODE_W-1:0] op_i,
    input  logic [XLEN-1:0]      src_a_i,
    input  logic [XLEN-1:0]      src_b_i,
    output logic [XLEN-1:0]      result_o,
    output logic                 illegal_o
);

    localparam int unsigned CW = $clog2(XLEN + 1);

    logic [CW-1:0]   lead_cnt, trail_cnt, ones_cnt;
    logic [XLEN-1:0] andinv_r, orinv_r, xnor_r;
    logic [XLEN-1:0] smin_r, smax_r, umin_r, umax_r;
    logic [XLEN-1:0] sxbyte_r, sxhalf_r;
    logic [XLEN-1:0] pklo_r, pkhi_r, pkbyte_r;
    bpu_op_e         op_sel;

    bpu_count #(.XLEN(XLEN)) u_count (
        .val_i   (src_a_i),
        .lead_o  (lead_cnt),
        .trail_o (trail_cnt),
        .ones_o  (ones_cnt)
    );

    bpu_logic #(.XLEN(XLEN)) u_logic (
        .a_i      (src_a_i),
        .b_i      (src_b_i),
        .andinv_o (andinv_r),
        .orinv_o  (orinv_r),
        .xnor_o   (xnor_r),
        .smin_o   (smin_r),
        .smax_o   (smax_r),
        .umin_o   (umin_r),
        .umax_o   (umax_r),
        .sxbyte_o (sxbyte_r),
        .sxhalf_o (sxhalf_r)
    );

    bpu_pack #(.XLEN(XLEN)) u_pack (
        .a_i      (src_a_i),
        .b_i      (src_b_i),
        .pklo_o   (pklo_r),
        .pkhi_o   (pkhi_r),
        .pkbyte_o (pkbyte_r)
    );

    // Read the raw code as the operation type.
    always_comb begin
        op_sel = bpu_op_e'(op_i);
    end

    // Result selection; the default arm covers every unimplemented code.
    always_comb begin
        illegal_o = 1'b0;
        case (op_sel)
            OP_LZCNT:  result_o = {{(XLEN-CW){1'b0}}, lead_cnt};
            OP_TZCNT:  result_o = {{(XLEN-CW){1'b0}}, trail_cnt};
            OP_POPCNT: result_o = {{(XLEN-CW){1'b0}}, ones_cnt};
            OP_ANDINV: result_o = andinv_r;
            OP_ORINV:  result_o = orinv_r;
            OP_XNOR:   result_o = xnor_r;
            OP_SMIN:   result_o = smin_r;
            OP_SMAX:   result_o = smax_r;
            OP_UMIN:   result_o = umin_r;
            OP_UMAX:   result_o = umax_r;
            OP_SXBYTE: result_o = sxbyte_r;
            OP_SXHALF: result_o = sxhalf_r;
            OP_PKLO:   result_o = pklo_r;
            OP_PKHI:   result_o = pkhi_r;
            OP_PKBYTE: result_o = pkbyte_r;
            default: begin
                result_o  = '0;
                illegal_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bitpack_unit_chk.sv
// Property checker for bitpack_unit. The unit has no clock, so every check
// here is an immediate assertion made on the settled combinational values.
module bitpack_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic [4:0]      op_i,
    input logic [XLEN-1:0] src_a_i,
    input logic [XLEN-1:0] src_b_i,
    input logic [XLEN-1:0] result_o,
    input logic            illegal_o
);

    // Relate the outputs to the inputs for the operations a property can capture.
    always_comb begin
        if (op_i == 5'd0 && src_a_i == '0) begin
            // R1
            lzcnt_zero_chk: assert (result_o == XLEN);
        end
        if (op_i == 5'd1 && src_a_i == '0) begin
            // R2
            tzcnt_zero_chk: assert (result_o == XLEN);
        end
        if (op_i == 5'd2) begin
            // R3
            popcnt_match_chk: assert (result_o == $countones(src_a_i));
        end
        if (op_i == 5'd6 || op_i == 5'd7) begin
            // R5
            sminmax_pick_chk: assert (result_o == src_a_i || result_o == src_b_i);
        end
        if (op_i == 5'd8) begin
            // R6
            umin_bound_chk: assert (result_o <= src_a_i && result_o <= src_b_i);
        end
        if (op_i == 5'd10) begin
            // R7
            sxbyte_fill_chk: assert (result_o[XLEN-1:7] == '0 || result_o[XLEN-1:7] == '1);
        end
        if (op_i == 5'd14) begin
            // R10
            pkbyte_upper_chk: assert (result_o[XLEN-1:16] == '0);
        end
        // R11
        illegal_flag_chk: assert (illegal_o == (op_i > 5'd14));
        if (illegal_o) begin
            // R11
            illegal_zero_chk: assert (result_o == '0);
        end
    end

endmodule

bind bitpack_unit bitpack_unit_chk #(.XLEN(XLEN)) u_chk (
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/bitpack_unit_tb.sv
// Self-checking bench: directed corner operands, then seeded random operands,
// checked against reference functions written from the requirements.
module bitpack_unit_tb;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      op;
    logic [XLEN-1:0] a, b;
    logic [XLEN-1:0] res;
    logic            ill;
    int              tests = 0;
    int              fails = 0;
    bit              done = 1'b0;

    always #2.5 clk = ~clk;

    bitpack_unit #(.XLEN(XLEN)) u_dut (
        .op_i      (op),
        .src_a_i   (a),
        .src_b_i   (b),
        .result_o  (res),
        .illegal_o (ill)
    );

    // Requirement tag for each operation code.
    function automatic string req_of(input logic [4:0] c);
        case (c)
            5'd0: return "R1";
            5'd1: return "R2";
            5'd2: return "R3";
            5'd3, 5'd4, 5'd5: return "R4";
            5'd6, 5'd7: return "R5";
            5'd8, 5'd9: return "R6";
            5'd10, 5'd11: return "R7";
            5'd12: return "R8";
            5'd13: return "R9";
            5'd14: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Reference result written from the requirement text.
    function automatic logic [XLEN-1:0] model(input logic [4:0] c,
                                              input logic [XLEN-1:0] x,
                                              input logic [XLEN-1:0] y);
        int n;
        n = 0;
        case (c)
            5'd0: begin
                for (int i = XLEN - 1; i >= 0; i--) begin
                    if (x[i]) break;
                    n++;
                end
                return XLEN'(n);
            end
            5'd1: begin
                for (int i = 0; i < XLEN; i++) begin
                    if (x[i]) break;
                    n++;
                end
                return XLEN'(n);
            end
            5'd2: begin
                for (int i = 0; i < XLEN; i++) n += int'(x[i]);
                return XLEN'(n);
            end
            5'd3:  return x & ~y;
            5'd4:  return x | ~y;
            5'd5:  return ~(x ^ y);
            5'd6:  return ($signed(x) <= $signed(y)) ? x : y;
            5'd7:  return ($signed(x) >= $signed(y)) ? x : y;
            5'd8:  return (x <= y) ? x : y;
            5'd9:  return (x >= y) ? x : y;
            5'd10: return XLEN'($signed(x[7:0]));
            5'd11: return XLEN'($signed(x[15:0]));
            5'd12: return {y[15:0], x[15:0]};
            5'd13: return {y[31:16], x[31:16]};
            5'd14: return {16'h0, y[7:0], x[7:0]};
            default: return '0;
        endcase
    endfunction

    // Apply one operation, let the outputs settle, and compare.
    task automatic check(input logic [4:0] c, input logic [XLEN-1:0] x,
                         input logic [XLEN-1:0] y);
        logic [XLEN-1:0] exp_r;
        logic            exp_i;
        @(negedge clk);
        op = c; a = x; b = y;
        #1;
        exp_r = model(c, x, y);
        exp_i = (c > 5'd14);
        tests++;
        if (res !== exp_r || ill !== exp_i) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h: got res=%h ill=%b, expected res=%h ill=%b",
                     req_of(c), c, x, y, res, ill, exp_r, exp_i);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] corners [4];
        int unsigned     seed_sink;
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = 32'h8000_0000;
        corners[3] = 32'h0000_0001;
        seed_sink = $urandom(32'd20240611);
        op = 5'd0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: the zero operand with code 0 gives a count of XLEN (R1).
        check(5'd0, '0, '0);

        // Every corner pairing for every implemented code (R1 to R10).
        for (int c = 0; c < 15; c++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    check(5'(c), corners[i], corners[j]);

        // Zero counts of XLEN (R1, R2).
        check(5'd0, '0, 32'h1234_5678);
        check(5'd1, '0, 32'h1234_5678);
        // Signed versus unsigned comparison of the same pair (R5, R6).
        check(5'd6, 32'h8000_0000, 32'h0000_0001);
        check(5'd8, 32'h8000_0000, 32'h0000_0001);
        // Distinct fields reveal any misplacement (R8, R9, R10).
        check(5'd12, 32'hA1B2_C3D4, 32'h5566_7788);
        check(5'd13, 32'hA1B2_C3D4, 32'h5566_7788);
        check(5'd14, 32'hA1B2_C3D4, 32'h5566_7788);
        // Sign bit set versus clear (R7).
        check(5'd10, 32'h0000_0080, '0);
        check(5'd11, 32'h0000_7FFF, '0);

        // Every unimplemented code (R11).
        for (int c = 15; c < 32; c++) check(5'(c), 32'hDEAD_BEEF, 32'hCAFE_F00D);

        // Random operands, with single-bit operands mixed in to stress the counters.
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]      c;
            logic [XLEN-1:0] x, y;
            c = 5'($urandom_range(0, 31));
            x = $urandom;
            y = $urandom;
            if ((k % 5) == 0) x = 32'h1 << $urandom_range(0, 31);
            check(c, x, y);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule